// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block sits between a processor's instruction-fetch port and a single-beat system bus read port, and serves instruction fetches from code that is not cached. Once a fetch has set a starting point, the block reads the words that follow it on its own and keeps them in a four-entry queue. A sequential fetch whose address is the oldest queued word is answered from the queue in the next cycle, with no bus traffic. Any other fetch goes to the bus as a demand read. A demand read always goes out before any further speculative read.

Only sequential words are read ahead, and no branch target is guessed. The queue is emptied when the core makes a nonsequential fetch, when address translation is switched on or off, and when the instruction cache is switched on. A branch therefore works as an instruction barrier after code has been changed. Speculation is on by default and stops while `spec_disable` is high. A bus response for a speculative read that was overtaken by a flush is thrown away.

The control FSM has four states. `S_IDLE` accepts fetches. `S_MISS_ISSUE` waits for the bus engine to become free. `S_MISS_WAIT` waits for the demand data. `S_CATCH` waits for a speculative read already on the bus for the requested word. Its transitions are:
- IDLE→MISS_ISSUE on a miss.
- IDLE→CATCH on a fetch that matches the in-flight word.
- MISS_ISSUE→MISS_WAIT when the demand is started.
- MISS_WAIT→IDLE on the demand response.
- CATCH→IDLE when the speculative word arrives.
- CATCH→MISS_ISSUE when a flush kills the in-flight word.

The bus engine has three states:
- `B_IDLE`→`B_ADDR` on a start.
- `B_ADDR`→`B_DATA` on grant.
- `B_DATA`→`B_IDLE` on response.

Top module: `seq_prefetch_buf`

## Requirements
- R1: After reset `core_ready` is 1 and `bus_req` and `core_rvalid` are 0. No bus read occurs until the core makes its first fetch.
- R2: After a demand read of address A with no further fetches, exactly five bus reads occur: A plus four speculative words. The bus then stays quiet.
- R3: Speculative reads go out in strictly increasing word order. Each one addresses the previous speculative read plus 4 until a flush.
- R4: A sequential fetch of the oldest queued word returns `core_rvalid` with its data one cycle after acceptance, without a bus read. The freed entry allows exactly one further speculative read.
- R5: A nonsequential fetch empties the queue and reads its address on the bus. A queued word whose memory changed is still returned unchanged to a sequential fetch, but a branch to it returns the new contents.
- R6: A change of `xlat_en` in either direction, or a rising `icache_en`, empties the queue. The next sequential fetch then sees current memory.
- R7: While `spec_disable` is 1, the only bus reads are the core's own fetches: one bus read per fetch.
- R8: A response for a speculative read that was issued before a flush is never stored. Later fetches return data of their own addresses.
- R9: After a miss, the next bus read other than one already under way is the demand address.
- R10: Every word returned to the core equals memory at that address when it was read. This also holds when a sequential fetch waits for a speculative read in flight.
- R11: `bus_req` and `bus_addr` are held stable until `bus_gnt`. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spec_disable | input | 1 | 1 stops read-ahead and keeps the queue empty |
| xlat_en | input | 1 | Address translation state; any change flushes |
| icache_en | input | 1 | Instruction cache state; a rise flushes |
| core_req | input | 1 | Fetch request, taken when `core_ready` is 1 |
| core_addr | input | AW | Fetch byte address, word aligned |
| core_seq | input | 1 | Fetch is sequential (previous address plus 4) |
| core_ready | output | 1 | Block can accept a fetch |
| core_rvalid | output | 1 | One-cycle pulse with the fetched word |
| core_rdata | output | DW | Fetched instruction word |
| bus_req | output | 1 | Bus read request |
| bus_addr | output | AW | Bus read address |
| bus_gnt | input | 1 | Bus accepts the request |
| bus_rvalid | input | 1 | Read data valid, at least one cycle after grant |
| bus_rdata | input | DW | Read data |

## Verification
A wrong queue count or read pointer shows up at the first hit after it occurs: `core_rdata` carries the word of a neighbouring address, and that shows against the memory model within one fetch. A flush that does not happen, or a dropped response that gets stored, is hidden until a sequential fetch reaches the affected word. The bench therefore changes memory under a filled queue and fetches those exact addresses. A broken address generator or depth limit appears on the bus within a few dozen cycles, as a wrong read count or address order in the bench's grant log.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {K_DEM, K_SPEC, K_DROP} xfer_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_MISS_ISSUE, S_MISS_WAIT, S_CATCH} ctl_state_e;
    typedef enum logic [1:0] {B_IDLE, B_ADDR, B_DATA} bus_state_e;
endpackage

// File: rtl/pf_store.sv
module pf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;

    assign wr_ptr    = rd_ptr + count[PW-1:0];
    assign head_data = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= rd_ptr + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !clear && wr_ptr == PW'(g)) slot[g] <= push_data;
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> count < CW'(DEPTH));
    a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
endmodule

// File: rtl/pf_bus_engine.sv
module pf_bus_engine
    import pf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_dem,
    input  logic [AW-1:0] dem_addr,
    input  logic          start_spec,
    input  logic [AW-1:0] spec_addr,
    input  logic          kill,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_gnt,
    input  logic          bus_rvalid,
    input  logic [DW-1:0] bus_rdata,
    output logic          idle,
    output xfer_kind_e    cur_kind,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data
);
    bus_state_e state, nxt;
    xfer_kind_e kind_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            B_IDLE: if (start_dem || start_spec) nxt = B_ADDR;
            B_ADDR: if (bus_gnt)                 nxt = B_DATA;
            B_DATA: if (bus_rvalid)              nxt = B_IDLE;
            default:                             nxt = B_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_DEM;
            addr_q <= '0;
        end else if (state == B_IDLE && start_dem) begin
            kind_q <= K_DEM;
            addr_q <= dem_addr;
        end else if (state == B_IDLE && start_spec) begin
            kind_q <= K_SPEC;
            addr_q <= spec_addr;
        end else if (state != B_IDLE && kill && kind_q == K_SPEC) begin
            kind_q <= K_DROP;
        end
    end

    always_comb begin
        bus_req    = (state == B_ADDR);
        bus_addr   = addr_q;
        idle       = (state == B_IDLE);
        cur_kind   = kind_q;
        resp_valid = (state == B_DATA) && bus_rvalid;
        resp_data  = bus_rdata;
    end

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr));
    a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt |=> !bus_req);
endmodule

// File: rtl/seq_prefetch_buf.sv
module seq_prefetch_buf
    import pf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spec_disable,
    input  logic          xlat_en,
    input  logic          icache_en,
    input  logic          core_req,
    input  logic [AW-1:0] core_addr,
    input  logic          core_seq,
    output logic          core_ready,
    output logic          core_rvalid,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_gnt,
    input  logic          bus_rvalid,
    input  logic [DW-1:0] bus_rdata
);
    localparam logic [AW-1:0] WSTEP = AW'(4);

    ctl_state_e state, nxt;
    logic [AW-1:0] base, dem_addr, pf_addr;
    logic          have_base, xlat_q, icache_q;
    logic [CW-1:0] cnt;
    logic [DW-1:0] head_data, resp_data;
    logic          eng_idle, resp_valid;
    xfer_kind_e    eng_kind;
    logic accept, match, hit, catch_now, miss, flush_ctl, flush_now;
    logic resp_ok, resp_dem, fwd, push, start_dem, start_spec;

    always_comb begin
        flush_ctl = (xlat_en != xlat_q) || (icache_en && !icache_q) || spec_disable;
        accept    = core_req && (state == S_IDLE);
        match     = core_seq && have_base && (core_addr == base);
        hit       = accept && match && (cnt != '0) && !flush_ctl;
        catch_now = accept && match && (cnt == '0) && !eng_idle
                    && (eng_kind == K_SPEC) && !flush_ctl;
        miss      = accept && !hit && !catch_now;
        flush_now = flush_ctl || miss;
        resp_ok   = resp_valid && (eng_kind == K_SPEC) && !flush_now;
        resp_dem  = resp_valid && (eng_kind == K_DEM) && (state == S_MISS_WAIT);
        fwd       = resp_ok && ((state == S_CATCH) || catch_now);
        push      = resp_ok && !fwd;
        pf_addr   = base + (AW'(cnt) << 2);
        start_dem = (state == S_MISS_ISSUE) && eng_idle;
        start_spec = !spec_disable && have_base && (state == S_IDLE) && eng_idle
                     && (cnt < CW'(DEPTH)) && !flush_now;
        core_ready = (state == S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (miss)                       nxt = S_MISS_ISSUE;
                else if (catch_now && !fwd)     nxt = S_CATCH;
            end
            S_MISS_ISSUE: if (eng_idle)         nxt = S_MISS_WAIT;
            S_MISS_WAIT:  if (resp_dem)         nxt = S_IDLE;
            S_CATCH: begin
                if (fwd)                        nxt = S_IDLE;
                else if (flush_ctl)             nxt = S_MISS_ISSUE;
            end
            default:                            nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base        <= '0;
            dem_addr    <= '0;
            have_base   <= 1'b0;
            xlat_q      <= 1'b0;
            icache_q    <= 1'b0;
            core_rvalid <= 1'b0;
            core_rdata  <= '0;
        end else begin
            xlat_q      <= xlat_en;
            icache_q    <= icache_en;
            core_rvalid <= hit || fwd || resp_dem;
            if (accept) dem_addr <= core_addr;
            if (miss)   have_base <= 1'b0;
            if (hit) begin
                base       <= base + WSTEP;
                core_rdata <= head_data;
            end else if (fwd) begin
                base       <= base + WSTEP;
                core_rdata <= resp_data;
            end else if (resp_dem) begin
                base       <= dem_addr + WSTEP;
                have_base  <= 1'b1;
                core_rdata <= resp_data;
            end
        end
    end

    pf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(flush_now), .push(push),
        .push_data(resp_data), .pop(hit), .head_data(head_data), .count(cnt)
    );

    pf_bus_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk(clk), .rst_n(rst_n), .start_dem(start_dem), .dem_addr(dem_addr),
        .start_spec(start_spec), .spec_addr(pf_addr), .kill(flush_now),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .idle(eng_idle),
        .cur_kind(eng_kind), .resp_valid(resp_valid), .resp_data(resp_data)
    );

    // ordering tracker for speculative issue
    logic [AW-1:0] last_spec;
    logic          last_v;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_v    <= 1'b0;
            last_spec <= '0;
        end else if (flush_now) begin
            last_v    <= 1'b0;
        end else if (start_spec) begin
            last_v    <= 1'b1;
            last_spec <= pf_addr;
        end
    end

    a_r3_increasing: assert property (@(posedge clk) disable iff (!rst_n)
        start_spec && last_v |-> pf_addr == last_spec + WSTEP);
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_now) |-> cnt == '0);
    a_r7_demand_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && spec_disable && $past(spec_disable) |-> eng_kind != K_SPEC);
    a_r8_drop_unstored: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && eng_kind == K_DROP |-> !push);
    a_r4_hit_answers: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> core_rvalid && core_ready);
endmodule

// File: tb/seq_prefetch_buf_bench.sv
`timescale 1ns/1ps
module seq_prefetch_buf_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spec_disable = 1'b0, xlat_en = 1'b0, icache_en = 1'b0;
    logic core_req = 1'b0, core_seq = 1'b0;
    logic [31:0] core_addr = '0;
    logic core_ready, core_rvalid, bus_req, bus_gnt;
    logic [31:0] core_rdata, bus_addr;
    logic bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    seq_prefetch_buf u_seq_prefetch_buf (
        .clk(clk), .rst_n(rst_n), .spec_disable(spec_disable), .xlat_en(xlat_en),
        .icache_en(icache_en), .core_req(core_req), .core_addr(core_addr),
        .core_seq(core_seq), .core_ready(core_ready), .core_rvalid(core_rvalid),
        .core_rdata(core_rdata), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    // memory model and bus responder
    logic [31:0] mem [64];
    int lat_cfg = 3;
    logic gnt_block = 1'b0;
    logic pend = 1'b0;
    int dly = 0;
    logic [31:0] paddr = '0;
    logic [31:0] glog [256];
    int gcnt = 0;
    int n_chk = 0, n_err = 0;

    assign bus_gnt = bus_req && !gnt_block;

    always @(posedge clk) begin
        bus_rvalid <= 1'b0;
        if (bus_req && bus_gnt) begin
            pend  <= 1'b1;
            paddr <= bus_addr;
            dly   <= lat_cfg - 1;
            glog[gcnt % 256] <= bus_addr;
            gcnt  <= gcnt + 1;
        end else if (pend) begin
            if (dly == 0) begin
                bus_rvalid <= 1'b1;
                bus_rdata  <= mem[paddr[7:2]];
                pend       <= 1'b0;
            end else dly <= dly - 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input logic s, output logic [31:0] d, output int lat);
        @(negedge clk);
        while (!core_ready) @(negedge clk);
        core_req = 1'b1; core_addr = a; core_seq = s;
        @(negedge clk);
        core_req = 1'b0;
        lat = 1;
        while (!core_rvalid) begin @(negedge clk); lat++; end
        d = core_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // table: {gap[3:0], seq, addr[7:0]}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {4'd0, 1'b0, 8'h00}, {4'd0, 1'b1, 8'h04}, {4'd0, 1'b1, 8'h08},
        {4'd8, 1'b1, 8'h0C}, {4'd0, 1'b1, 8'h10}, {4'd0, 1'b1, 8'h14},
        {4'd0, 1'b0, 8'h60}, {4'd0, 1'b1, 8'h64}, {4'd10, 1'b1, 8'h68},
        {4'd0, 1'b1, 8'h6C}, {4'd0, 1'b0, 8'h20}, {4'd3, 1'b1, 8'h24}
    };

    initial begin
        #(100000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d, oldv;
        int lat, g0, k;
        for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE0000 + i * 32'h00010003;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'd0, core_ready}, 32'd1);
        chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
        chk("R1 rvalid", {31'd0, core_rvalid}, 32'd0);
        idle(10);
        chk("R1 no reads before first fetch", gcnt, 0);

        // table walk (R10 with catch and hit paths, R5 branches)
        for (int v = 0; v < NV; v++) begin
            idle(int'(VEC[v][12:9]));
            fetch({24'd0, VEC[v][7:0]}, VEC[v][8], d, lat);
            chk($sformatf("R10 vec%0d", v), d, mem[VEC[v][7:2]]);
        end

        // R2/R3 depth and order, lat 1
        lat_cfg = 1;
        idle(40);
        g0 = gcnt;
        fetch(32'h40, 1'b0, d, lat);
        chk("R10 demand 40", d, mem[16]);
        idle(40);
        chk("R2 read count", gcnt - g0, 5);
        for (int j = 0; j < 5; j++)
            chk($sformatf("R3 order %0d", j), glog[(g0 + j) % 256], 32'h40 + 4 * j);
        fetch(32'h44, 1'b1, d, lat);
        chk("R4 hit latency", lat, 1);
        chk("R4 hit data", d, mem[17]);
        idle(20);
        chk("R4 refill count", gcnt - g0, 6);
        chk("R4 refill addr", glog[(g0 + 5) % 256], 32'h54);

        // R5 stale until branch
        oldv = mem[19];
        mem[19] = 32'h5EAF0013;
        fetch(32'h48, 1'b1, d, lat);
        chk("R5 hit 48", d, mem[18]);
        fetch(32'h4C, 1'b1, d, lat);
        chk("R5 queued word unchanged", d, oldv);
        fetch(32'h4C, 1'b0, d, lat);
        chk("R5 branch sees new", d, 32'h5EAF0013);

        // R6 translation toggle and cache enable
        fetch(32'h80, 1'b0, d, lat);
        idle(30);
        fetch(32'h84, 1'b1, d, lat);
        chk("R6 hit 84", d, mem[33]);
        mem[34] = 32'hA11CE022;
        @(negedge clk); xlat_en = 1'b1;
        idle(30);
        fetch(32'h88, 1'b1, d, lat);
        chk("R6 xlat flush", d, 32'hA11CE022);
        idle(30);
        mem[35] = 32'hB0B0C023;
        @(negedge clk); icache_en = 1'b1;
        idle(30);
        fetch(32'h8C, 1'b1, d, lat);
        chk("R6 icache flush", d, 32'hB0B0C023);
        @(negedge clk); icache_en = 1'b0; xlat_en = 1'b0;
        idle(30);

        // R7 speculation off
        spec_disable = 1'b1;
        idle(20);
        g0 = gcnt;
        fetch(32'hA0, 1'b0, d, lat);
        chk("R7 data A0", d, mem[40]);
        idle(5);
        fetch(32'hA4, 1'b1, d, lat);
        chk("R7 data A4", d, mem[41]);
        idle(5);
        fetch(32'hA8, 1'b1, d, lat);
        idle(20);
        chk("R7 reads equal fetches", gcnt - g0, 3);
        spec_disable = 1'b0;

        // R8/R9 dropped speculative response
        lat_cfg = 6;
        idle(10);
        fetch(32'h00, 1'b0, d, lat);
        g0 = gcnt;
        fetch(32'hC0, 1'b0, d, lat);
        chk("R9 demand C0", d, mem[48]);
        k = g0;
        while (k < gcnt && glog[k % 256] == 32'h04) k++;
        chk("R9 first new read", glog[k % 256], 32'hC0);
        fetch(32'hC4, 1'b1, d, lat);
        chk("R8 C4 not stale", d, mem[49]);
        fetch(32'hC8, 1'b1, d, lat);
        chk("R8 C8", d, mem[50]);

        // R11 request held without grant
        lat_cfg = 2;
        idle(60);
        gnt_block = 1'b1;
        @(negedge clk);
        core_req = 1'b1; core_addr = 32'h10; core_seq = 1'b0;
        @(negedge clk);
        core_req = 1'b0;
        idle(3);
        chk("R11 req held", {31'd0, bus_req}, 32'd1);
        chk("R11 addr held", bus_addr, 32'h10);
        idle(2);
        chk("R11 addr stable", bus_addr, 32'h10);
        gnt_block = 1'b0;
        while (!core_rvalid) @(negedge clk);
        chk("R11 data", core_rdata, mem[4]);

        idle(10);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule